// File: doc/BRIEF.md
# Segmented Page Table Entry Locator

This block finds where a page table entry sits in memory when paging is combined with segmentation. A virtual address is split into three fields. The top two bits name a segment. The next eighteen bits give the page number inside that segment. The low twelve bits are the byte offset within the page.

Each segment owns a pair of registers. One holds the physical start address of that segment's linear page table. The other holds how many pages of the segment are in use. A request returns the entry address, which is the table start plus four times the page number. If the page number is not below the segment's page count, the request returns a fault instead.

The register pairs are loaded through a small write port. The answer is registered and appears exactly one cycle after the request. Reading the entry from memory and caching translations are left to neighbouring blocks.

Top module: `ptloc_top`

## Requirements
- R1: After reset, `rsp_valid` is low and every table start and page count is zero, so any lookup made before programming returns a fault.
- R2: Bits [31:30] of `req_vaddr` select which segment's register pair is used, with value s choosing pair s.
- R3: A lookup that is not faulted returns `rsp_pte_addr` = table start + 4 × page number, where the page number is `req_vaddr`[29:12] and the sum wraps modulo 2^32.
- R4: A lookup faults when the page number is greater than or equal to the segment's page count. A page number of count−1 does not fault, and a count of zero faults every page.
- R5: Whenever `rsp_fault` is high, `rsp_pte_addr` is zero.
- R6: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. When `rsp_valid` is low, `rsp_fault` and `rsp_pte_addr` are zero. Back-to-back requests each get their own response.
- R7: When `cfg_we` is high, `cfg_sel`[2:1] names the segment and `cfg_sel`[0] picks the register: 0 for table start (all 32 bits of `cfg_data`) and 1 for page count (`cfg_data`[18:0]). A count of 2^18 makes every page of the segment valid.
- R8: A lookup made in the same cycle as a register write uses the register values from before that write.
- R9: Offset bits `req_vaddr`[11:0] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Segment (bits 2:1) and register kind (bit 0) |
| cfg_data | input | 32 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to locate |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_fault | output | 1 | Page number outside the segment's count |
| rsp_pte_addr | output | 32 | Physical address of the entry, zero on fault |

## Verification
The assertions assume the inputs are at known levels whenever reset is released. They also assume that `req_vaddr` only has meaning while `req_valid` is high, so they look at lookup-side signals only in cycles that carry a request. The bench drives every input on the falling clock edge, so each value is stable at the edge that registers it. It keeps `req_valid` low outside the directed lookups, and it reads the answers one edge later, in the cycle given by the one-cycle latency.

// File: rtl/ptloc_pkg.sv
package ptloc_pkg;

  typedef enum logic {
    KIND_BASE  = 1'b0,
    KIND_COUNT = 1'b1
  } reg_kind_e;

  localparam int DEF_VA_W      = 32;
  localparam int DEF_SEG_W     = 2;
  localparam int DEF_OFF_W     = 12;
  localparam int DEF_PA_W      = 32;
  localparam int DEF_ENT_SHIFT = 2;

endpackage

// File: rtl/ptloc_seg_regs.sv
module ptloc_seg_regs #(
  parameter int SEG_W   = 2,
  parameter int PA_W    = 32,
  parameter int CNT_W   = 19,
  localparam int NSEG   = 1 << SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  ptloc_pkg::reg_kind_e wr_kind,
  input  logic [PA_W-1:0]  wr_data,
  input  logic [SEG_W-1:0] rd_seg,
  output logic [PA_W-1:0]  rd_base,
  output logic [CNT_W-1:0] rd_count
);

  logic [PA_W-1:0]  base_q  [NSEG];
  logic [CNT_W-1:0] count_q [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic hit;
    assign hit = wr_en && (wr_seg == SEG_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[s]  <= '0;
        count_q[s] <= '0;
      end else if (hit) begin
        if (wr_kind == ptloc_pkg::KIND_BASE) base_q[s] <= wr_data;
        else                                 count_q[s] <= wr_data[CNT_W-1:0];
      end
    end
  end

  assign rd_base  = base_q[rd_seg];
  assign rd_count = count_q[rd_seg];

endmodule

// File: rtl/ptloc_calc.sv
module ptloc_calc #(
  parameter int VPN_W     = 18,
  parameter int PA_W      = 32,
  parameter int ENT_SHIFT = 2,
  localparam int CNT_W    = VPN_W + 1
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [PA_W-1:0]  base,
  input  logic [CNT_W-1:0] count,
  output logic             over,
  output logic [PA_W-1:0]  entry_addr
);

  function automatic logic page_outside(input logic [VPN_W-1:0] p,
                                        input logic [CNT_W-1:0] c);
    return {1'b0, p} >= c;
  endfunction

  function automatic logic [PA_W-1:0] entry_of(input logic [PA_W-1:0] b,
                                              input logic [VPN_W-1:0] p);
    logic [PA_W-1:0] scaled;
    scaled = PA_W'({p, {ENT_SHIFT{1'b0}}});
    return b + scaled;
  endfunction

  assign over       = page_outside(vpn, count);
  assign entry_addr = entry_of(base, vpn);

endmodule

// File: rtl/ptloc_top.sv
module ptloc_top #(
  parameter int VA_W      = ptloc_pkg::DEF_VA_W,
  parameter int SEG_W     = ptloc_pkg::DEF_SEG_W,
  parameter int OFF_W     = ptloc_pkg::DEF_OFF_W,
  parameter int PA_W      = ptloc_pkg::DEF_PA_W,
  parameter int ENT_SHIFT = ptloc_pkg::DEF_ENT_SHIFT,
  localparam int VPN_W    = VA_W - SEG_W - OFF_W,
  localparam int CNT_W    = VPN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEG_W:0]   cfg_sel,
  input  logic [PA_W-1:0]  cfg_data,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_pte_addr
);

  logic [SEG_W-1:0] lk_seg;
  logic [VPN_W-1:0] lk_vpn;
  logic [PA_W-1:0]  lk_base;
  logic [CNT_W-1:0] lk_count;
  logic             lk_over;
  logic [PA_W-1:0]  lk_addr;
  ptloc_pkg::reg_kind_e wr_kind;

  assign lk_seg  = req_vaddr[VA_W-1 -: SEG_W];
  assign lk_vpn  = req_vaddr[OFF_W +: VPN_W];
  assign wr_kind = ptloc_pkg::reg_kind_e'(cfg_sel[0]);

  ptloc_seg_regs #(
    .SEG_W (SEG_W),
    .PA_W  (PA_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_seg   (cfg_sel[SEG_W:1]),
    .wr_kind  (wr_kind),
    .wr_data  (cfg_data),
    .rd_seg   (lk_seg),
    .rd_base  (lk_base),
    .rd_count (lk_count)
  );

  ptloc_calc #(
    .VPN_W     (VPN_W),
    .PA_W      (PA_W),
    .ENT_SHIFT (ENT_SHIFT)
  ) u_calc (
    .vpn        (lk_vpn),
    .base       (lk_base),
    .count      (lk_count),
    .over       (lk_over),
    .entry_addr (lk_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_pte_addr <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_fault    <= req_valid && lk_over;
      rsp_pte_addr <= (req_valid && !lk_over) ? lk_addr : '0;
    end
  end

endmodule

// File: rtl/ptloc_chk.sv
module ptloc_chk #(
  parameter int PA_W  = 32,
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             lk_over,
  input logic [CNT_W-1:0] lk_count,
  input logic [PA_W-1:0]  lk_addr,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_pte_addr
);

  p_resp_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_pte_addr == '0));

  p_outside_faults_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lk_over) |=> rsp_fault);

  p_empty_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lk_count == '0) |=> rsp_fault);

  p_fault_zero_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_pte_addr == '0 && rsp_valid));

  p_inside_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lk_over) |=> (!rsp_fault && rsp_pte_addr == $past(lk_addr)));

endmodule

bind ptloc_top ptloc_chk #(
  .PA_W  (PA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .lk_over      (lk_over),
  .lk_count     (lk_count),
  .lk_addr      (lk_addr),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_pte_addr (rsp_pte_addr)
);

// File: tb/tb_ptloc_top.sv
module tb_ptloc_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [31:0] rsp_pte_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_base  [4];
  logic [18:0] m_count [4];

  always #10 clk = ~clk;

  ptloc_top dut (
    .clk (clk), .rst_n (rst_n),
    .cfg_we (cfg_we), .cfg_sel (cfg_sel), .cfg_data (cfg_data),
    .req_valid (req_valid), .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid), .rsp_fault (rsp_fault), .rsp_pte_addr (rsp_pte_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_va(input int seg, input int vpn, input int off);
    return (32'(seg) << 30) | ((32'(vpn) & 32'h3FFFF) << 12) | (32'(off) & 32'hFFF);
  endfunction

  task automatic wr(input int seg, input bit is_count, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = {2'(seg), is_count}; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (is_count) m_count[seg] = d[18:0]; else m_base[seg] = d;
  endtask

  // Expected response from the model of R3/R4/R5.
  task automatic expect_rsp(input string req, input int seg, input int vpn);
    logic flt;
    logic [31:0] ea;
    flt = (vpn >= int'(m_count[seg]));
    ea  = flt ? 32'h0 : m_base[seg] + 32'(vpn) * 32'd4;
    chk({req, " valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " fault"}, 32'(rsp_fault), 32'(flt));
    chk({req, " addr"}, rsp_pte_addr, ea);
  endtask

  task automatic look(input string req, input int seg, input int vpn, input int off);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = mk_va(seg, vpn, off);
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = 32'hDEAD_BEEF;
    expect_rsp(req, seg, vpn);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", 32'(rsp_valid), 32'd0);
    look("R1 unprogrammed", 2, 7, 0);
    chk("R1 unprogrammed faults", 32'(rsp_fault), 32'd1);
  endtask

  task automatic t_program_translate();
    wr(0, 0, 32'h0010_0000); wr(0, 1, 32'd100);
    wr(1, 0, 32'h0020_0400); wr(1, 1, 32'd5);
    wr(2, 0, 32'h8000_0000); wr(2, 1, 32'h0004_0000);
    wr(3, 0, 32'hFFFF_FFF0); wr(3, 1, 32'd16);
    look("R2 R3 seg0", 0, 37, 0);
    look("R2 R3 seg1", 1, 3, 0);
    look("R2 R3 seg2", 2, 1000, 0);
    look("R2 R3 seg3", 3, 2, 0);
  endtask

  task automatic t_bounds();
    look("R4 last page", 1, 4, 0);
    chk("R4 last page passes", 32'(rsp_fault), 32'd0);
    look("R4 R5 at count", 1, 5, 0);
    chk("R4 at count faults", 32'(rsp_fault), 32'd1);
    look("R4 R5 far beyond", 0, 200000, 0);
    look("R7 full count top page", 2, 262143, 0);
    chk("R7 top page passes", 32'(rsp_fault), 32'd0);
    wr(0, 1, 32'd0);
    look("R4 zero count", 0, 0, 0);
    chk("R4 zero count faults", 32'(rsp_fault), 32'd1);
  endtask

  task automatic t_wrap_offset();
    look("R3 wrap", 3, 8, 0);
    chk("R3 wrap value", rsp_pte_addr, 32'h0000_0010);
    look("R9 offset zero", 1, 2, 0);
    begin
      logic [31:0] a0;
      a0 = rsp_pte_addr;
      look("R9 offset full", 1, 2, 32'hFFF);
      chk("R9 offset ignored", rsp_pte_addr, a0);
    end
  endtask

  task automatic t_latency();
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = mk_va(1, 1, 0);
    @(negedge clk);
    expect_rsp("R6 first of pair", 1, 1);
    req_vaddr = mk_va(3, 3, 5);
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R6 second of pair", 3, 3);
    @(negedge clk);
    chk("R6 idle valid", 32'(rsp_valid), 32'd0);
    chk("R6 idle fault", 32'(rsp_fault), 32'd0);
    chk("R6 idle addr", rsp_pte_addr, 32'd0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = {2'd1, 1'b1}; cfg_data = 32'd0;
    req_valid = 1'b1; req_vaddr = mk_va(1, 2, 0);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    expect_rsp("R8 old count used", 1, 2);
    m_count[1] = 19'd0;
    look("R8 new count after", 1, 2, 0);
    chk("R8 new count faults", 32'(rsp_fault), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_count[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program_translate();
    t_bounds();
    t_wrap_offset();
    t_latency();
    t_same_cycle();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule